// File: doc/BRIEF.md
# Memory-Reference Execute Controller

This block carries out the execute steps of the seven memory-reference operations of a 16-bit single-accumulator processor. Its operations are logical AND, add with carry, load, store, unconditional jump, jump-and-link and increment-and-skip-if-zero. A fetch unit hands over an accepted instruction as a 3-bit operation field and a 12-bit effective address. At the same time it hands over the program counter, accumulator and link bit that the instruction works on. The block then steps a 4-bit sequence count from step 4 up to at most step 6. At each step it drives the memory read or write strobe and updates its working registers. It clears the count as soon as the operation is complete.

The timing is fixed for each operation. Store and jump finish in one step, and AND, add, load and jump-and-link finish in two. Increment-and-skip-if-zero reads the word, increments it and writes it back, so it needs three steps and is the longest operation. Jump-and-link stores the return address in the target word and continues one word past it, so that a subroutine can return through that word. The memory is outside the block: the address comes from the address register, reads are combinational and writes take effect on the clock edge.

Top module: `mri_exec`

## Requirements
- R1: A synchronous active-high reset clears the sequence count, so `busy` is 0, and sets AR, PC, DR, AC and E to zero.
- R2: A `start` with `op` = 7 (a non-memory instruction) is ignored. `busy` stays 0, AC, PC and E keep their values, and no memory strobe is raised.
- R3: `op` = 0 (AND) sets AC to AC AND M[EA] and leaves E unchanged. It is busy for 2 cycles.
- R4: `op` = 1 (ADD) sets {E, AC} to the 17-bit sum AC + M[EA]. It is busy for 2 cycles.
- R5: `op` = 2 (LDA) sets AC to M[EA] and leaves E unchanged. It is busy for 2 cycles.
- R6: `op` = 3 (STA) writes AC to M[EA] in its first busy cycle and leaves AC unchanged. It is busy for 1 cycle.
- R7: `op` = 4 (BUN) sets PC to EA. It is busy for 1 cycle.
- R8: `op` = 5 (BSA) writes the incoming PC, zero-extended to 16 bits, to M[EA]. It then sets PC to (EA + 1) mod 4096 and is busy for 2 cycles.
- R9: `op` = 6 (ISZ) writes M[EA] + 1 (mod 2^16) back to M[EA]. If the result is zero, PC advances by 1 mod 4096. It is busy for 3 cycles, which no operation exceeds.
- R10: A `start` raised while `busy` is 1 is ignored, and the operation in flight completes unchanged.
- R11: `mem_rd` is raised only in the first busy cycle of AND, ADD, LDA and ISZ, with `mem_addr` equal to EA. `mem_rd` and `mem_wr` are never high together, and both are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Hands over an instruction; taken only when idle |
| op | input | 3 | Operation field: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 not memory-reference |
| ea | input | 12 | Effective address |
| pc_in | input | 12 | Program counter at hand-over |
| ac_in | input | 16 | Accumulator at hand-over |
| e_in | input | 1 | Link bit at hand-over |
| mem_addr | output | 12 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe, written on the clock edge |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, combinational |
| busy | output | 1 | Sequence count is nonzero |
| ac | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| e | output | 1 | Link bit |
| ar | output | 12 | Address register |
| dr | output | 16 | Data register |

## Verification
A table of vectors runs every operation on chosen words, and each vector is compared for AC, PC, E, the target word and the busy length. ADD is run once without and once with a carry out, so that a link bit that is not updated is caught. AND uses complementary nibble patterns, which separate it from add or load. ISZ is run on a nonzero word, on 0xFFFF, and on 0xFFFF with PC at 0xFFF, which covers the skip, the lack of a skip and the wrap of PC. BSA runs once with the example call and once at address 0xFFF, where the continuation address wraps. Directed tests cover reset, an ignored non-memory operation and a `start` raised mid-operation.

// File: rtl/mri_pkg.sv
package mri_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int SC_W    = 4;
    localparam int OP_W    = 3;
    localparam int NUM_MR  = (1 << OP_W) - 1;
    localparam int T_FIRST = 4;
    localparam int T_LAST  = 6;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_NMR = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        WSRC_AC = 2'd0,
        WSRC_PC = 2'd1,
        WSRC_DR = 2'd2
    } wsrc_e;

    typedef struct packed {
        logic  dr_ld_mem;
        logic  dr_inc;
        logic  ac_and;
        logic  ac_add;
        logic  ac_ld_dr;
        logic  ar_inc;
        logic  pc_ld_ar;
        logic  pc_inc;
        logic  mem_rd;
        logic  mem_wr;
        wsrc_e wsrc;
        logic  sc_clr;
    } ctrl_t;

    function automatic logic is_mem_ref(input logic [OP_W-1:0] o);
        return o != OP_NMR;
    endfunction

    function automatic logic [WORD_W-1:0] addr_to_word(input logic [ADDR_W-1:0] a);
        return {{(WORD_W-ADDR_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/mri_opdec.sv
module mri_opdec
    import mri_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [OP_W-1:0]     op,
    output logic [NUM_MR-1:0]   dline
);
    for (genvar i = 0; i < NUM_MR; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                dline[i] <= 1'b0;
            else if (capture)
                dline[i] <= (op == OP_W'(i));
        end
    end
endmodule

// File: rtl/mri_timing.sv
module mri_timing
    import mri_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   clr,
    output logic                   busy,
    output logic [T_LAST:T_FIRST]  tline
);
    logic [SC_W-1:0] sc;

    always_ff @(posedge clk) begin
        if (rst)
            sc <= '0;
        else if (load)
            sc <= SC_W'(T_FIRST);
        else if (clr)
            sc <= '0;
        else if (sc != '0)
            sc <= sc + SC_W'(1);
    end

    assign busy = (sc != '0);

    for (genvar t = T_FIRST; t <= T_LAST; t++) begin : g_step
        assign tline[t] = (sc == SC_W'(t));
    end
endmodule

// File: rtl/mri_ctrl.sv
module mri_ctrl
    import mri_pkg::*;
(
    input  logic [NUM_MR-1:0]      dline,
    input  logic [T_LAST:T_FIRST]  tline,
    input  logic                   dr_zero,
    output ctrl_t                  ctrl
);
    logic t4, t5, t6;
    logic d_and, d_add, d_lda, d_sta, d_bun, d_bsa, d_isz;

    assign t4    = tline[T_FIRST];
    assign t5    = tline[T_FIRST+1];
    assign t6    = tline[T_LAST];
    assign d_and = dline[OP_AND];
    assign d_add = dline[OP_ADD];
    assign d_lda = dline[OP_LDA];
    assign d_sta = dline[OP_STA];
    assign d_bun = dline[OP_BUN];
    assign d_bsa = dline[OP_BSA];
    assign d_isz = dline[OP_ISZ];

    always_comb begin
        ctrl           = '0;
        ctrl.dr_ld_mem = t4 & (d_and | d_add | d_lda | d_isz);
        ctrl.mem_rd    = ctrl.dr_ld_mem;
        ctrl.mem_wr    = (t4 & (d_sta | d_bsa)) | (t6 & d_isz);
        ctrl.wsrc      = d_bsa ? WSRC_PC : (d_isz ? WSRC_DR : WSRC_AC);
        ctrl.ar_inc    = t4 & d_bsa;
        ctrl.pc_ld_ar  = (t4 & d_bun) | (t5 & d_bsa);
        ctrl.ac_and    = t5 & d_and;
        ctrl.ac_add    = t5 & d_add;
        ctrl.ac_ld_dr  = t5 & d_lda;
        ctrl.dr_inc    = t5 & d_isz;
        ctrl.pc_inc    = t6 & d_isz & dr_zero;
        ctrl.sc_clr    = (t4 & (d_sta | d_bun))
                       | (t5 & (d_and | d_add | d_lda | d_bsa))
                       | (t6 & d_isz);
    end
endmodule

// File: rtl/mri_datapath.sv
module mri_datapath
    import mri_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  ea,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [WORD_W-1:0]  ac_in,
    input  logic               e_in,
    input  ctrl_t              ctrl,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               dr_zero,
    output logic [ADDR_W-1:0]  ar,
    output logic [ADDR_W-1:0]  pc,
    output logic [WORD_W-1:0]  dr,
    output logic [WORD_W-1:0]  ac,
    output logic               e
);
    logic [WORD_W:0] sum;

    assign sum     = {1'b0, ac} + {1'b0, dr};
    assign dr_zero = (dr == '0);

    always_comb begin
        unique case (ctrl.wsrc)
            WSRC_PC: mem_wdata = addr_to_word(pc);
            WSRC_DR: mem_wdata = dr;
            default: mem_wdata = ac;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar <= '0;
            pc <= '0;
            dr <= '0;
            ac <= '0;
            e  <= 1'b0;
        end else if (load) begin
            ar <= ea;
            pc <= pc_in;
            ac <= ac_in;
            e  <= e_in;
        end else begin
            if (ctrl.ar_inc)
                ar <= ar + ADDR_W'(1);
            if (ctrl.dr_ld_mem)
                dr <= mem_rdata;
            else if (ctrl.dr_inc)
                dr <= dr + WORD_W'(1);
            if (ctrl.ac_and)
                ac <= ac & dr;
            else if (ctrl.ac_add)
                {e, ac} <= sum;
            else if (ctrl.ac_ld_dr)
                ac <= dr;
            if (ctrl.pc_ld_ar)
                pc <= ar;
            else if (ctrl.pc_inc)
                pc <= pc + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/mri_exec.sv
module mri_exec
    import mri_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [OP_W-1:0]    op,
    input  logic [ADDR_W-1:0]  ea,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [WORD_W-1:0]  ac_in,
    input  logic               e_in,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               busy,
    output logic [WORD_W-1:0]  ac,
    output logic [ADDR_W-1:0]  pc,
    output logic               e,
    output logic [ADDR_W-1:0]  ar,
    output logic [WORD_W-1:0]  dr
);
    logic                   accept;
    logic [NUM_MR-1:0]      dline;
    logic [T_LAST:T_FIRST]  tline;
    logic                   dr_zero;
    ctrl_t                  ctrl;

    assign accept = start & ~busy & is_mem_ref(op);

    mri_opdec u_opdec (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .op      (op),
        .dline   (dline)
    );

    mri_timing u_timing (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .clr   (ctrl.sc_clr),
        .busy  (busy),
        .tline (tline)
    );

    mri_ctrl u_ctrl (
        .dline   (dline),
        .tline   (tline),
        .dr_zero (dr_zero),
        .ctrl    (ctrl)
    );

    mri_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .ea        (ea),
        .pc_in     (pc_in),
        .ac_in     (ac_in),
        .e_in      (e_in),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .dr_zero   (dr_zero),
        .ar        (ar),
        .pc        (pc),
        .dr        (dr),
        .ac        (ac),
        .e         (e)
    );

    assign mem_addr = ar;
    assign mem_rd   = ctrl.mem_rd;
    assign mem_wr   = ctrl.mem_wr;
endmodule

// File: rtl/mri_exec_chk.sv
module mri_exec_chk
    import mri_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [OP_W-1:0]    op,
    input  logic [ADDR_W-1:0]  ea,
    input  logic [WORD_W-1:0]  ac_in,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic [WORD_W-1:0]  mem_wdata,
    input  logic               busy,
    input  logic [WORD_W-1:0]  ac,
    input  logic [ADDR_W-1:0]  pc
);
    logic [2:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)
            busy_len <= '0;
        else if (busy)
            busy_len <= busy_len + 3'd1;
        else
            busy_len <= '0;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!busy && ac == '0 && pc == '0));

    p_nonmem_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 3'd7) |=> !busy);

    p_sta_write_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 3'd3) |=> (mem_wr && mem_wdata == $past(ac_in)));

    p_bun_target_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 3'd4) |=> ##1 (pc == $past(ea, 2)));

    p_max_len_r9: assert property (@(posedge clk) disable iff (rst)
        busy_len <= 3'd3);

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));
endmodule

bind mri_exec mri_exec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .ea        (ea),
    .ac_in     (ac_in),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .ac        (ac),
    .pc        (pc)
);

// File: tb/mri_exec_tb.sv
module mri_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [11:0] ea = '0;
    logic [11:0] pc_in = '0;
    logic [15:0] ac_in = '0;
    logic        e_in = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, e;
    logic [15:0] ac, dr;
    logic [11:0] pc, ar;

    logic [15:0] mem [0:4095];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    mri_exec dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .ea(ea),
        .pc_in(pc_in), .ac_in(ac_in), .e_in(e_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .ac(ac), .pc(pc), .e(e), .ar(ar), .dr(dr)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] ea;
        logic [11:0] pc0;
        logic [15:0] ac0;
        logic        e0;
        logic [15:0] m0;
        logic [15:0] x_ac;
        logic [11:0] x_pc;
        logic        x_e;
        logic [15:0] x_m;
        logic [2:0]  x_len;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 12'h010, 12'h020, 16'h3C3C, 1'b0, 16'hF0F0, 16'h3030, 12'h020, 1'b0, 16'hF0F0, 3'd2, 8'd3}, // R3 AND
        '{3'd1, 12'h011, 12'h020, 16'h00FF, 1'b1, 16'h0001, 16'h0100, 12'h020, 1'b0, 16'h0001, 3'd2, 8'd4}, // R4 ADD, no carry
        '{3'd1, 12'h012, 12'h020, 16'h8001, 1'b0, 16'h8000, 16'h0001, 12'h020, 1'b1, 16'h8000, 3'd2, 8'd4}, // R4 ADD, carry
        '{3'd2, 12'h013, 12'h020, 16'h1234, 1'b1, 16'hBEEF, 16'hBEEF, 12'h020, 1'b1, 16'hBEEF, 3'd2, 8'd5}, // R5 LDA
        '{3'd3, 12'h040, 12'h020, 16'hCAFE, 1'b0, 16'h0000, 16'hCAFE, 12'h020, 1'b0, 16'hCAFE, 3'd1, 8'd6}, // R6 STA
        '{3'd4, 12'h123, 12'h021, 16'h0007, 1'b1, 16'h5555, 16'h0007, 12'h123, 1'b1, 16'h5555, 3'd1, 8'd7}, // R7 BUN
        '{3'd5, 12'h087, 12'h015, 16'h0009, 1'b0, 16'h7777, 16'h0009, 12'h088, 1'b0, 16'h0015, 3'd2, 8'd8}, // R8 BSA call 135 from 21
        '{3'd5, 12'hFFF, 12'h100, 16'h0000, 1'b1, 16'h1111, 16'h0000, 12'h000, 1'b1, 16'h0100, 3'd2, 8'd8}, // R8 BSA wrap
        '{3'd6, 12'h200, 12'h030, 16'h4444, 1'b0, 16'h0005, 16'h4444, 12'h030, 1'b0, 16'h0006, 3'd3, 8'd9}, // R9 ISZ no skip
        '{3'd6, 12'h201, 12'h030, 16'h4444, 1'b1, 16'hFFFF, 16'h4444, 12'h031, 1'b1, 16'h0000, 3'd3, 8'd9}, // R9 ISZ skip
        '{3'd6, 12'h202, 12'hFFF, 16'h0000, 1'b0, 16'hFFFF, 16'h0000, 12'h000, 1'b0, 16'h0000, 3'd3, 8'd9}  // R9 ISZ skip, PC wrap
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected=<50000", cycles);
            summary();
            $finish;
        end
    end

    // Issue one instruction from a negedge; returns busy length and first-step strobes.
    task automatic issue(input logic [2:0] o, input logic [11:0] a, input logic [11:0] p,
                         input logic [15:0] acc, input logic ee,
                         output int len, output logic rd0, output logic wr0,
                         output logic [11:0] addr0);
        op = o; ea = a; pc_in = p; ac_in = acc; e_in = ee; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rd0 = mem_rd; wr0 = mem_wr; addr0 = mem_addr;
        len = 0;
        while (busy && len < 10) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        int len;
        logic rd0, wr0;
        logic [11:0] addr0;
        logic [15:0] sav_ac;
        logic [11:0] sav_pc;
        logic sav_e;

        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy, "R1", "busy after reset", 32'(busy), 0);
        chk(ac == 0 && pc == 0 && e == 0, "R1", "ac/pc/e after reset", {ac, pc, 3'b0, e}, 0);
        chk(ar == 0 && dr == 0, "R1", "ar/dr after reset", {ar, 4'b0, dr}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d", v.req);
            mem[v.ea] = v.m0;
            issue(v.op, v.ea, v.pc0, v.ac0, v.e0, len, rd0, wr0, addr0);
            chk(ac == v.x_ac, rq, $sformatf("vec %0d ac", i), 32'(ac), 32'(v.x_ac));
            chk(pc == v.x_pc, rq, $sformatf("vec %0d pc", i), 32'(pc), 32'(v.x_pc));
            chk(e == v.x_e, rq, $sformatf("vec %0d e", i), 32'(e), 32'(v.x_e));
            chk(mem[v.ea] == v.x_m, rq, $sformatf("vec %0d mem word", i), 32'(mem[v.ea]), 32'(v.x_m));
            chk(len == int'(v.x_len), rq, $sformatf("vec %0d busy length", i), 32'(len), 32'(v.x_len));
            // R11 read strobe only in first step of AND/ADD/LDA/ISZ, at EA
            chk(rd0 == (v.op inside {3'd0, 3'd1, 3'd2, 3'd6}), "R11",
                $sformatf("vec %0d first-step mem_rd", i), 32'(rd0),
                32'(v.op inside {3'd0, 3'd1, 3'd2, 3'd6}));
            chk(addr0 == v.ea, "R11", $sformatf("vec %0d first-step mem_addr", i), 32'(addr0), 32'(v.ea));
            chk(!(rd0 && wr0), "R11", $sformatf("vec %0d rd and wr together", i), {rd0, wr0}, 0);
        end

        // R2: non-memory operation is ignored
        sav_ac = ac; sav_pc = pc; sav_e = e;
        mem[12'h300] = 16'hABCD;
        issue(3'd7, 12'h300, 12'h777, 16'hFFFF, ~sav_e, len, rd0, wr0, addr0);
        chk(len == 0, "R2", "busy length for op 7", 32'(len), 0);
        chk(!rd0 && !wr0, "R2", "strobes for op 7", {rd0, wr0}, 0);
        chk(ac == sav_ac && pc == sav_pc && e == sav_e, "R2", "state after op 7",
            {ac, pc, 3'b0, e}, {sav_ac, sav_pc, 3'b0, sav_e});
        chk(mem[12'h300] == 16'hABCD, "R2", "mem after op 7", 32'(mem[12'h300]), 32'h ABCD);

        // R10: start while busy is ignored
        mem[12'h050] = 16'h0010;
        op = 3'd1; ea = 12'h050; pc_in = 12'h060; ac_in = 16'h0005; e_in = 1'b1; start = 1'b1;
        @(negedge clk);
        op = 3'd4; ea = 12'h7AA; pc_in = 12'h0AA; ac_in = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        len = 0;
        while (busy && len < 10) begin
            len++;
            @(negedge clk);
        end
        chk(ac == 16'h0015, "R10", "ac after ignored start", 32'(ac), 32'h15);
        chk(pc == 12'h060, "R10", "pc after ignored start", 32'(pc), 32'h60);
        chk(e == 1'b0, "R10", "e after ignored start", 32'(e), 0);

        // R1 reset mid-operation
        op = 3'd6; ea = 12'h210; pc_in = 12'h001; ac_in = 16'h1; e_in = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && ac == 0 && pc == 0, "R1", "state after mid-op reset", {busy, ac, pc}, 0);
        @(negedge clk);
        chk(!mem_rd && !mem_wr, "R11", "strobes while idle", {mem_rd, mem_wr}, 0);

        summary();
        $finish;
    end
endmodule